// File: doc/BRIEF.md
# External Bus Ready-Wait Controller

This block runs one read or one write at a time on an external memory-style bus whose strobes are all active low and whose target answers with an active-low ready line. The internal side gives a one-clock start pulse together with an address, write data and a direction bit. The block then pulls chip select low. On a write it also pulls write enable low after a programmable lag. On a read it pulls output enable low. It holds off looking at ready until a programmable wait has gone by, and it then finishes the cycle by the rule for the direction: a write ends one edge after ready is seen, and a read captures data two edges after ready is seen.

If ready never arrives, the block ends the cycle itself once the wait plus 256 clocks have passed, and it reports a bus error. The end of every cycle is reported by a one-clock done or error pulse, and the captured read data is returned alongside it. Reads and writes each have their own 4-bit wait field. The wait fields and the write-enable lag are taken at the moment a request is accepted.

Top module: `xbus_rdy_ctrl`

## Requirements
- R1: The wait length is W = field + 1, giving 1 to 16 clocks. The read field applies to reads and the write field applies to writes, and both are latched when the request is accepted. Numbering the clocks with chip select low from 1, ready is first examined in clock W+1.
- R2: The ready input passes through a two-flop synchronizer. When it is driven low during active clock L, it is seen in clock L+2. A low level that arrives before clock W+1 does not shorten the cycle, so the first clock in which ready is seen is s = max(W+1, L+2).
- R3: On a write that sees ready in clock s, chip select stays low for exactly s+1 clocks.
- R4: On a read that sees ready in clock s, chip select stays low for exactly s+2 clocks. The read data is captured at the rising edge that ends the last of those clocks and is presented on rsp_rdata together with the done pulse.
- R5: If ready is still high after 256 examined clocks, the cycle ends with chip select low for W+256 clocks, and it ends with an error pulse in place of a done pulse.
- R6: With ready held low all along, a write holds chip select low for W+2 clocks and a read holds it low for W+3 clocks.
- R7: On a write, write enable is low from active clock lag+1 to the end of the cycle, where lag is 0 to 3. Output enable stays high on a write. On a read, output enable is low for every active clock and write enable stays high.
- R8: Done or error is high for exactly one clock, and that clock is the first one after chip select returns high. The two are never high together.
- R9: Chip select, write enable and output enable are all high whenever the block is idle, including in the clock that carries the done or error pulse.
- R10: A start pulse is accepted only while busy is low, and chip select goes low in the next clock. A start pulse while busy is ignored and not queued. The address and write data on the bus are those latched at acceptance, and they stay unchanged for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-clock start pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| cfg_rd_wait | input | 4 | Read wait field, wait = value + 1 |
| cfg_wr_wait | input | 4 | Write wait field, wait = value + 1 |
| cfg_we_lag | input | 2 | Clocks from chip select low to write enable low |
| busy | output | 1 | High while a cycle is in progress |
| rsp_done | output | 1 | One-clock pulse on normal completion |
| rsp_err | output | 1 | One-clock pulse on ready timeout |
| rsp_rdata | output | DW | Captured read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data |
| bus_rdy_n | input | 1 | Ready from the target, active low |

## Verification
Almost any corruption of the phase register or of the shared wait and timeout counter shows up at the ports in the same cycle. It appears as chip select staying low for the wrong number of clocks, and the error is off by whole clocks: a wrong wait length, a missing synchronizer stage, or a read that ends one edge early. A slip in the read capture point shows as read data from the neighbouring clock, because the bench changes the data on the bus every clock. A stuck counter or phase instead holds chip select low past the longest legal cycle, and the length bound in the checker catches that within 274 clocks.

// File: rtl/xbus_rdy_pkg.sv
package xbus_rdy_pkg;
    localparam int WAIT_FW = 4;
    localparam int LAG_FW  = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT,
        PH_SAMPLE,
        PH_WEND,
        PH_RD1,
        PH_RD2
    } phase_e;
endpackage

// File: rtl/xbus_rdy_sync.sv
module xbus_rdy_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/xbus_we_lag.sv
module xbus_we_lag #(
    parameter int LAG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             wr,
    input  logic [LAG_W-1:0] lag,
    output logic             we_n
);
    localparam logic [LAG_W-1:0] CNT_MAX = {LAG_W{1'b1}};

    logic [LAG_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!active)               cnt_d = '0;
        else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
        else                       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // cnt_q is k-1 in active clock k, so the strobe starts at k = lag+1
    assign we_n = !(active && wr && (cnt_q >= lag));
endmodule

// File: rtl/xbus_rdy_ctrl.sv
module xbus_rdy_ctrl
    import xbus_rdy_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 32,
    parameter int TMO         = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_start,
    input  logic               req_write,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    input  logic [WAIT_FW-1:0] cfg_rd_wait,
    input  logic [WAIT_FW-1:0] cfg_wr_wait,
    input  logic [LAG_FW-1:0]  cfg_we_lag,
    output logic               busy,
    output logic               rsp_done,
    output logic               rsp_err,
    output logic [DW-1:0]      rsp_rdata,
    output logic               bus_cs_n,
    output logic               bus_we_n,
    output logic               bus_oe_n,
    output logic [AW-1:0]      bus_addr,
    output logic [DW-1:0]      bus_wdata,
    input  logic [DW-1:0]      bus_rdata,
    input  logic               bus_rdy_n
);
    localparam int TMO_BITS = $clog2(TMO);
    localparam int CW       = (TMO_BITS > WAIT_FW) ? TMO_BITS : WAIT_FW;
    localparam logic [CW-1:0] TMO_LAST = CW'(TMO - 1);

    typedef struct packed {
        phase_e             ph;
        logic [CW-1:0]      cnt;
        logic               wr;
        logic [LAG_FW-1:0]  lag;
        logic [WAIT_FW-1:0] wm1;
        logic [AW-1:0]      addr;
        logic [DW-1:0]      wdata;
        logic [DW-1:0]      rdata;
        logic               done;
        logic               err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic rdy_sync_n;
    logic active;

    xbus_rdy_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (bus_rdy_n),
        .dout  (rdy_sync_n)
    );

    assign active = (ctl_q.ph != PH_IDLE);

    xbus_we_lag #(
        .LAG_W (LAG_FW)
    ) u_we (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .wr     (ctl_q.wr),
        .lag    (ctl_q.lag),
        .we_n   (bus_we_n)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (req_start) begin
                    ctl_d.ph    = PH_WAIT;
                    ctl_d.cnt   = '0;
                    ctl_d.wr    = req_write;
                    ctl_d.lag   = cfg_we_lag;
                    ctl_d.wm1   = req_write ? cfg_wr_wait : cfg_rd_wait;
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                end
            end
            PH_WAIT: begin
                if (ctl_q.cnt == CW'(ctl_q.wm1)) begin
                    ctl_d.ph  = PH_SAMPLE;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            PH_SAMPLE: begin
                if (!rdy_sync_n) begin
                    ctl_d.ph = ctl_q.wr ? PH_WEND : PH_RD1;
                end else if (ctl_q.cnt == TMO_LAST) begin
                    ctl_d.ph  = PH_IDLE;
                    ctl_d.err = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            PH_WEND: begin
                ctl_d.ph   = PH_IDLE;
                ctl_d.done = 1'b1;
            end
            PH_RD1: begin
                ctl_d.ph = PH_RD2;
            end
            PH_RD2: begin
                ctl_d.ph    = PH_IDLE;
                ctl_d.done  = 1'b1;
                ctl_d.rdata = bus_rdata;
            end
            default: begin
                ctl_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.ph    <= PH_IDLE;
            ctl_q.cnt   <= '0;
            ctl_q.wr    <= 1'b0;
            ctl_q.lag   <= '0;
            ctl_q.wm1   <= '0;
            ctl_q.addr  <= '0;
            ctl_q.wdata <= '0;
            ctl_q.rdata <= '0;
            ctl_q.done  <= 1'b0;
            ctl_q.err   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy      = active;
    assign bus_cs_n  = !active;
    assign bus_oe_n  = !(active && !ctl_q.wr);
    assign bus_addr  = ctl_q.addr;
    assign bus_wdata = ctl_q.wdata;
    assign rsp_done  = ctl_q.done;
    assign rsp_err   = ctl_q.err;
    assign rsp_rdata = ctl_q.rdata;
endmodule

// File: rtl/xbus_rdy_ctrl_chk.sv
module xbus_rdy_ctrl_chk #(
    parameter int AW  = 16,
    parameter int TMO = 256
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_start,
    input logic          busy,
    input logic          rsp_done,
    input logic          rsp_err,
    input logic          bus_cs_n,
    input logic          bus_we_n,
    input logic          bus_oe_n,
    input logic [AW-1:0] bus_addr
);
    localparam int MAXLEN = 16 + TMO + 2;
    localparam int LW     = $clog2(MAXLEN + 2);

    logic [LW-1:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              low_q <= '0;
        else if (bus_cs_n)                       low_q <= '0;
        else if (low_q != LW'(MAXLEN + 1))       low_q <= low_q + 1'b1;
    end

    // R9
    strobes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> (bus_we_n && bus_oe_n));

    // R7
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |-> bus_oe_n);

    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_done && rsp_err));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R8
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |=> !rsp_err);

    // R8
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> (rsp_done || rsp_err));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done || rsp_err) |-> (bus_cs_n && $past(!bus_cs_n)));

    // R10
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && !busy) |=> !bus_cs_n);

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs_n |=> (bus_cs_n || $stable(bus_addr)));

    // R5
    max_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs_n |-> (low_q < LW'(MAXLEN)));
endmodule

bind xbus_rdy_ctrl xbus_rdy_ctrl_chk #(
    .AW  (AW),
    .TMO (TMO)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_start (req_start),
    .busy      (busy),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err),
    .bus_cs_n  (bus_cs_n),
    .bus_we_n  (bus_we_n),
    .bus_oe_n  (bus_oe_n),
    .bus_addr  (bus_addr)
);

// File: tb/xbus_rdy_ctrl_test.sv
module xbus_rdy_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 12;
    localparam int DW  = 16;
    localparam int TMO = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_start = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [3:0]    cfg_rd_wait = '0;
    logic [3:0]    cfg_wr_wait = '0;
    logic [1:0]    cfg_we_lag = '0;
    logic          busy, rsp_done, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic          bus_cs_n, bus_we_n, bus_oe_n;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_rdy_n = 1'b1;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_rdy_ctrl #(.AW(AW), .DW(DW), .TMO(TMO), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_rd_wait(cfg_rd_wait),
        .cfg_wr_wait(cfg_wr_wait), .cfg_we_lag(cfg_we_lag), .busy(busy),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rdy_n(bus_rdy_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int idx);
        return DW'(idx * 291 + 23040);
    endfunction

    // One bus cycle. rdy_at = 0: ready tied low; otherwise driven low from active clock rdy_at.
    task automatic run_cycle(input bit wr, input int wf, input int lag, input int rdy_at,
                             input bit stray);
        int w, s, len, we_cnt, we_first, oe_cnt, idx;
        bit timeout, side_bad;
        logic [AW-1:0] a;
        logic [DW-1:0] wd;
        string tag;
        w = wf + 1;
        a  = AW'(wf * 97 + lag * 13 + rdy_at + (wr ? 5 : 0));
        wd = DW'(wf * 4001 + rdy_at * 7 + lag);
        s = w + 1;
        if (rdy_at != 0 && rdy_at + 2 > s) s = rdy_at + 2;
        timeout = (s - w > TMO);
        if (timeout)  len = w + TMO;
        else if (wr)  len = s + 1;
        else          len = s + 2;
        if (timeout)          tag = "R5";
        else if (rdy_at == 0) tag = "R6";
        else if (wr)          tag = "R3 R1 R2";
        else                  tag = "R4 R1 R2";

        bus_rdy_n = (rdy_at == 0) ? 1'b0 : 1'b1;
        repeat (3) @(negedge clk);
        req_start = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        cfg_rd_wait = wr ? 4'(15 - wf) : 4'(wf);
        cfg_wr_wait = wr ? 4'(wf) : 4'(15 - wf);
        cfg_we_lag = 2'(lag);
        @(negedge clk);
        req_start = 1'b0;
        // change the configuration at once: it must have been latched (R1)
        cfg_rd_wait = ~cfg_rd_wait; cfg_wr_wait = ~cfg_wr_wait; cfg_we_lag = ~cfg_we_lag;
        idx = 0; we_cnt = 0; we_first = 0; oe_cnt = 0; side_bad = 1'b0;
        while (!bus_cs_n && idx < 400) begin
            idx++;
            if (!bus_we_n) begin
                we_cnt++;
                if (we_first == 0) we_first = idx;
            end
            if (!bus_oe_n) oe_cnt++;
            if (bus_addr != a || bus_wdata != wd || !busy || rsp_done || rsp_err) side_bad = 1'b1;
            if (rdy_at != 0) bus_rdy_n = (idx >= rdy_at) ? 1'b0 : 1'b1;
            bus_rdata = pat(idx);
            if (stray) begin
                if (idx == 2) begin
                    req_start = 1'b1; req_addr = ~a; req_write = ~wr;
                end else if (idx == 3) begin
                    req_start = 1'b0; req_addr = a; req_write = wr;
                end
            end
            @(negedge clk);
        end
        chk({tag, " active length"}, idx, len);
        chk("R8 R5 end pulse done/err", {30'd0, rsp_done, rsp_err},
            timeout ? 1 : 2);
        chk("R10 address/data held, busy high", side_bad, 0);
        if (wr) begin
            chk("R7 write enable clocks", we_cnt, (len > lag) ? len - lag : 0);
            if (len > lag) chk("R7 write enable first clock", we_first, lag + 1);
            chk("R7 output enable on write", oe_cnt, 0);
        end else begin
            chk("R7 output enable clocks", oe_cnt, len);
            chk("R7 write enable on read", we_cnt, 0);
            if (!timeout) chk("R4 read data", int'(rsp_rdata), int'(pat(len)));
        end
        chk("R9 strobes high at end", {29'd0, bus_cs_n, bus_we_n, bus_oe_n}, 7);
        bus_rdy_n = 1'b1;
        @(negedge clk);
        chk("R8 pulse lasts one clock", {30'd0, rsp_done, rsp_err}, 0);
        chk("R10 no queued cycle", {31'd0, bus_cs_n}, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset cs_n", bus_cs_n, 1);
        chk("R9 reset we_n", bus_we_n, 1);
        chk("R9 reset oe_n", bus_oe_n, 1);
        chk("R8 reset pulses", {30'd0, rsp_done, rsp_err}, 0);
        chk("R10 reset busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R2 R3 R4 R6 R7 R10: sweep of wait, lag, and ready arrival
        for (int wr = 0; wr < 2; wr++)
            for (int wf = 0; wf < 16; wf++)
                for (int lag = 0; lag < 4; lag++) begin
                    run_cycle(wr[0], wf, lag, 0, lag == 2);
                    run_cycle(wr[0], wf, lag, 1, 1'b0);
                    run_cycle(wr[0], wf, lag, 3 + lag, 1'b0);
                    run_cycle(wr[0], wf, lag, 9 + wf, lag == 1);
                    run_cycle(wr[0], wf, lag, 19, 1'b0);
                end
        // R5: ready never arrives, and the last-examined-clock boundary
        for (int wr = 0; wr < 2; wr++) begin
            run_cycle(wr[0], 0, 0, 1000, 1'b0);
            run_cycle(wr[0], 15, 3, 1000, 1'b0);
            run_cycle(wr[0], 3, 1, 4 + TMO - 2, 1'b0);
            run_cycle(wr[0], 3, 1, 4 + TMO - 1, 1'b0);
        end
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule